// File: doc/BRIEF.md
# Fully Associative Multi-Page-Size Translation Buffer

This block translates a 64-bit virtual address into a physical address. It searches every entry of a fully associative table at the same time. Each entry pairs a tag with a data word. The tag holds the virtual page in its upper bits and an address-space context number in its low 13 bits. The data word carries a valid flag, a page-size code, a supervisor-only flag, a write-permission flag and the physical frame bits. Each entry chooses its own page size from four choices, 8 KB, 64 KB, 512 KB and 4 MB, so pages of different sizes share one table.

A lookup carries three qualifiers: whether it is an instruction fetch or a data access, whether a data access is a store, and whether the requester runs in user mode. One clock after the request the block returns one of three outcomes:
- a translation, together with whether writes are granted;
- a miss, reported with separate codes for the instruction side and the data side;
- a fault, when an entry matches but is invalid or forbids the access.

Faults are recorded in separate status registers for each side. A fault after an earlier, uncleared fault also sets an overflow flag. The data side additionally keeps the faulting address. Entries are loaded one at a time through an indexed write port. When translation is switched off, the address passes through unchanged.

Top module: `fa_tlb`

## Requirements
- R1: Each lookup request (`req_valid` high at a clock edge) produces `rsp_valid` high in the following cycle only. The response fields then hold until the next request.
- R2: An entry hits when two conditions hold. First, its tag bits [12:0] equal `ctx_id`. Second, the VA and the tag agree on all bits at and above a cutoff, where the tag's bits [12:0] are treated as zero. The cutoff is 13, 16, 19 or 22 for the page-size code in data bits [62:61] equal to 0, 1, 2 or 3.
- R3: On a clean hit `rsp_exc` is 0. `rsp_pa` takes the data word's bits from the cutoff up to bit 40 and the VA's bits from 12 up to the cutoff. All other `rsp_pa` bits are zero.
- R4: A hit on an entry whose valid bit (data bit 63) is clear is a fault. The fault code is 4 for data accesses and 3 for fetches.
- R5: A hit on an entry with the supervisor-only bit (data bit 2) set, made with `req_user` high, is a fault.
- R6: A data store (`req_write` high, `req_fetch` low) hitting an entry with the write bit (data bit 1) clear gives fault code 4. `req_write` has no effect on fetches.
- R7: When no entry hits, `rsp_exc` is 1 for a fetch and 2 for a data access. On any miss or fault `rsp_pa` is zero and `rsp_wr_ok` is low.
- R8: When several entries hit, the lowest-numbered entry supplies the result.
- R9: With `tr_enable` low, `rsp_pa` equals the VA and `rsp_exc` is 0. `rsp_wr_ok` is high for data accesses and low for fetches. The fault registers do not change.
- R10: On a clean hit `rsp_wr_ok` equals the entry's write bit for data accesses and is low for fetches.
- R11: A fault loads the status register of its side with bit 0 set, bit 3 equal to `req_user`, bit 2 equal to `req_write` (data side only; always 0 on the fetch side) and bit 1 set when the register was nonzero before. All earlier contents are discarded. `fsr_clr` zeroes both registers; a fault in the same cycle sees them as zero.
- R12: `dfar` captures the VA of every data-side fault. Fetch faults leave it unchanged.
- R13: Reset clears every entry to all-zero, drops `rsp_valid` and zeroes both status registers and `dfar`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tr_enable | input | 1 | Translation on; low passes addresses through |
| ctx_id | input | 13 | Current address-space context |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 6 | Entry number to load |
| wr_tag | input | 64 | Tag to load (page bits and context) |
| wr_data | input | 64 | Data word to load |
| req_valid | input | 1 | Lookup request |
| req_fetch | input | 1 | Instruction fetch (high) or data access (low) |
| req_write | input | 1 | Data store |
| req_user | input | 1 | Requester is in user mode |
| req_va | input | 64 | Virtual address |
| fsr_clr | input | 1 | Zero both fault status registers |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_exc | output | 3 | 0 ok, 1 fetch miss, 2 data miss, 3 fetch fault, 4 data fault |
| rsp_pa | output | 64 | Physical address (zero on miss or fault) |
| rsp_wr_ok | output | 1 | Write permission granted |
| dfsr | output | 4 | Data-side fault status |
| ifsr | output | 4 | Fetch-side fault status |
| dfar | output | 64 | Address of last data-side fault |

## Verification
The bench loads entries of all four page sizes and probes inside them and just past them. A design with a wrong mask width would return a wrong frame or a false hit. It also probes the top of the physical window, which catches a design that let stray data-word bits into `rsp_pa`.

Two entries with the same tag and different frames expose a priority encoder that picks the highest index. Stores through a read-only page and fetches with the write flag raised catch a write check applied on the wrong side. Back-to-back faults without a clear, a clear followed by a fetch-side fault, and the all-zero entries left by reset catch these errors:
- overflow reporting that ORs into old bits instead of replacing them;
- a fault address captured by fetch faults;
- a reset state that would hit as a miss instead of a fault.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int VA_BITS       = 64;
   localparam int CTX_BITS      = 13;
   localparam int PG_SHIFT_BASE = 13;
   localparam int PG_SHIFT_STEP = 3;

   localparam int DB_VALID   = 63;
   localparam int DB_SIZE_HI = 62;
   localparam int DB_SIZE_LO = 61;
   localparam int DB_SUPER   = 2;
   localparam int DB_WRITE   = 1;

   typedef enum logic [2:0] {
      EXC_NONE   = 3'd0,
      EXC_IMISS  = 3'd1,
      EXC_DMISS  = 3'd2,
      EXC_IFAULT = 3'd3,
      EXC_DFAULT = 3'd4
   } tlb_exc_e;

   // keep-mask for a page-size code: clears bits below 13 + 3*code
   function automatic logic [VA_BITS-1:0] pg_mask(input logic [1:0] code);
      int unsigned sh;
      sh = PG_SHIFT_BASE + PG_SHIFT_STEP * int'(code);
      return {VA_BITS{1'b1}} << sh;
   endfunction
endpackage

// File: rtl/tlb_cam_cmp.sv
module tlb_cam_cmp
   import tlb_pkg::*;
(
   input  logic [VA_BITS-1:0]  tag,
   input  logic [1:0]          pg_size,
   input  logic [VA_BITS-1:0]  va,
   input  logic [CTX_BITS-1:0] ctx,
   output logic                hit
);
   logic [VA_BITS-1:0] keep;
   logic [VA_BITS-1:0] tag_page;

   always_comb begin
      keep     = pg_mask(pg_size);
      tag_page = {tag[VA_BITS-1:CTX_BITS], {CTX_BITS{1'b0}}};
      hit      = (tag[CTX_BITS-1:0] == ctx) && ((va & keep) == tag_page);
   end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int N = 64
) (
   input  logic [N-1:0]         hit,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit[i]) idx = i[IW-1:0];
      end
   end

   assign any = |hit;
endmodule

// File: rtl/tlb_fault_log.sv
module tlb_fault_log
   import tlb_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               d_fault,
   input  logic               i_fault,
   input  logic               user,
   input  logic               write,
   input  logic [VA_BITS-1:0] va,
   output logic [3:0]         dfsr,
   output logic [3:0]         ifsr,
   output logic [VA_BITS-1:0] dfar
);
   logic [3:0]         dfsr_q, ifsr_q, d_base, i_base;
   logic [VA_BITS-1:0] dfar_q;

   always_comb begin
      d_base = clr ? 4'h0 : dfsr_q;
      i_base = clr ? 4'h0 : ifsr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dfsr_q <= '0;
         ifsr_q <= '0;
         dfar_q <= '0;
      end else begin
         if (d_fault) begin
            dfsr_q <= ((d_base != 4'h0) ? 4'b0010 : 4'b0000) | {user, write, 1'b0, 1'b1};
            dfar_q <= va;
         end else begin
            dfsr_q <= d_base;
         end
         if (i_fault) ifsr_q <= ((i_base != 4'h0) ? 4'b0010 : 4'b0000) | {user, 1'b0, 1'b0, 1'b1};
         else         ifsr_q <= i_base;
      end
   end

   assign dfsr = dfsr_q;
   assign ifsr = ifsr_q;
   assign dfar = dfar_q;
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int PA_HI   = 40,
   parameter int PA_LO   = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tr_enable,
   input  logic [CTX_BITS-1:0]        ctx_id,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic [VA_BITS-1:0]         wr_tag,
   input  logic [VA_BITS-1:0]         wr_data,
   input  logic                       req_valid,
   input  logic                       req_fetch,
   input  logic                       req_write,
   input  logic                       req_user,
   input  logic [VA_BITS-1:0]         req_va,
   input  logic                       fsr_clr,
   output logic                       rsp_valid,
   output logic [2:0]                 rsp_exc,
   output logic [VA_BITS-1:0]         rsp_pa,
   output logic                       rsp_wr_ok,
   output logic [3:0]                 dfsr,
   output logic [3:0]                 ifsr,
   output logic [VA_BITS-1:0]         dfar
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [VA_BITS-1:0] PA_WIN =
      ((64'd1 << (PA_HI + 1)) - 64'd1) & ~((64'd1 << PA_LO) - 64'd1);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("fa_tlb: ENTRIES must be a power of two of at least 2");
   end
   if (PA_HI >= VA_BITS - 1 || PA_LO < 0 || PA_LO > PA_HI || PA_LO > PG_SHIFT_BASE) begin : g_bad_window
      $error("fa_tlb: physical window bounds out of range");
   end

   logic [VA_BITS-1:0] tag_q  [ENTRIES];
   logic [VA_BITS-1:0] data_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end
      end else if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   logic [ENTRIES-1:0] hit_vec;
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
      tlb_cam_cmp u_cmp (
         .tag     (tag_q[g]),
         .pg_size (data_q[g][DB_SIZE_HI:DB_SIZE_LO]),
         .va      (req_va),
         .ctx     (ctx_id),
         .hit     (hit_vec[g])
      );
   end

   logic             any_hit;
   logic [IDX_W-1:0] sel_idx;
   tlb_first_hit #(.N(ENTRIES)) u_pick (
      .hit (hit_vec),
      .any (any_hit),
      .idx (sel_idx)
   );

   logic [VA_BITS-1:0] sel_data, sel_mask, tr_pa, pa_d;
   logic               prot_fault, wr_ok_d, log_d, log_i;
   tlb_exc_e           exc_d;

   always_comb begin
      sel_data   = data_q[sel_idx];
      sel_mask   = pg_mask(sel_data[DB_SIZE_HI:DB_SIZE_LO]);
      tr_pa      = (sel_data & sel_mask & PA_WIN) | (req_va & ~sel_mask & PA_WIN);
      prot_fault = !sel_data[DB_VALID]
                || (sel_data[DB_SUPER] && req_user)
                || (!req_fetch && req_write && !sel_data[DB_WRITE]);
      exc_d   = EXC_NONE;
      pa_d    = '0;
      wr_ok_d = 1'b0;
      if (!tr_enable) begin
         pa_d    = req_va;
         wr_ok_d = !req_fetch;
      end else if (!any_hit) begin
         exc_d = req_fetch ? EXC_IMISS : EXC_DMISS;
      end else if (prot_fault) begin
         exc_d = req_fetch ? EXC_IFAULT : EXC_DFAULT;
      end else begin
         pa_d    = tr_pa;
         wr_ok_d = !req_fetch && sel_data[DB_WRITE];
      end
      log_d = req_valid && (exc_d == EXC_DFAULT);
      log_i = req_valid && (exc_d == EXC_IFAULT);
   end

   logic               vld_q, wr_ok_q;
   tlb_exc_e           exc_q;
   logic [VA_BITS-1:0] pa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         exc_q   <= EXC_NONE;
         pa_q    <= '0;
         wr_ok_q <= 1'b0;
      end else begin
         vld_q <= req_valid;
         if (req_valid) begin
            exc_q   <= exc_d;
            pa_q    <= pa_d;
            wr_ok_q <= wr_ok_d;
         end
      end
   end

   tlb_fault_log u_flog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fsr_clr),
      .d_fault (log_d),
      .i_fault (log_i),
      .user    (req_user),
      .write   (req_write),
      .va      (req_va),
      .dfsr    (dfsr),
      .ifsr    (ifsr),
      .dfar    (dfar)
   );

   assign rsp_valid = vld_q;
   assign rsp_exc   = exc_q;
   assign rsp_pa    = pa_q;
   assign rsp_wr_ok = wr_ok_q;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tr_enable,
   input logic        req_valid,
   input logic        req_fetch,
   input logic [63:0] req_va,
   input logic        fsr_clr,
   input logic        rsp_valid,
   input logic [2:0]  rsp_exc,
   input logic [63:0] rsp_pa,
   input logic        rsp_wr_ok,
   input logic [3:0]  dfsr,
   input logic [63:0] dfar
);
   assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));

   assert_offset_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tr_enable) |=> (rsp_pa[11:0] == 12'h000));

   assert_err_pa_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc != 3'd0) |-> (rsp_pa == 64'd0 && !rsp_wr_ok));

   assert_fetch_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch) |=> (rsp_exc != 3'd2 && rsp_exc != 3'd4));

   assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !tr_enable) |=> (rsp_pa == $past(req_va) && rsp_exc == 3'd0));

   assert_fetch_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch) |=> !rsp_wr_ok);

   assert_dfault_logged_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc == 3'd4) |-> dfsr[0]);

   assert_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc == 3'd4 && $past(dfsr) != 4'h0 && !$past(fsr_clr)) |-> dfsr[1]);

   assert_dfar_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc == 3'd4) |-> (dfar == $past(req_va)));
endmodule

bind fa_tlb tlb_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tr_enable (tr_enable),
   .req_valid (req_valid),
   .req_fetch (req_fetch),
   .req_va    (req_va),
   .fsr_clr   (fsr_clr),
   .rsp_valid (rsp_valid),
   .rsp_exc   (rsp_exc),
   .rsp_pa    (rsp_pa),
   .rsp_wr_ok (rsp_wr_ok),
   .dfsr      (dfsr),
   .dfar      (dfar)
);

// File: tb/sim_fa_tlb.sv
`timescale 1ns/1ps
module sim_fa_tlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tr_enable = 1'b1;
   logic [12:0] ctx_id = '0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [63:0] wr_tag = '0, wr_data = '0;
   logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [63:0] req_va = '0;
   logic        fsr_clr = 1'b0;
   logic        rsp_valid, rsp_wr_ok;
   logic [2:0]  rsp_exc;
   logic [63:0] rsp_pa, dfar;
   logic [3:0]  dfsr, ifsr;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   fa_tlb u0 (
      .clk(clk), .rst_n(rst_n), .tr_enable(tr_enable), .ctx_id(ctx_id),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
      .req_valid(req_valid), .req_fetch(req_fetch), .req_write(req_write),
      .req_user(req_user), .req_va(req_va), .fsr_clr(fsr_clr),
      .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_pa(rsp_pa),
      .rsp_wr_ok(rsp_wr_ok), .dfsr(dfsr), .ifsr(ifsr), .dfar(dfar)
   );

   // row: req[138:135] fetch[134] write[133] user[132] va[131:68] exc[67:65] pa[64:1] wr_ok[0]
   localparam int ROW_W = 139;
   localparam int NROWS = 16;
   localparam logic [ROW_W-1:0] VEC [NROWS] = '{
      {4'd2,  1'b0,1'b0,1'b0, 64'h0000_0000_0040_1ABC, 3'd0, 64'h0000_0000_0AB0_1000, 1'b1}, // R2 8K
      {4'd10, 1'b0,1'b1,1'b1, 64'h0000_0000_0040_0000, 3'd0, 64'h0000_0000_0AB0_0000, 1'b1}, // R10 user store ok
      {4'd3,  1'b0,1'b0,1'b0, 64'h0000_0000_1234_ABCD, 3'd0, 64'h0000_0000_0055_A000, 1'b0}, // R3 64K
      {4'd6,  1'b0,1'b1,1'b0, 64'h0000_0000_1234_ABCD, 3'd4, 64'h0,                   1'b0}, // R6 store read-only
      {4'd6,  1'b1,1'b1,1'b0, 64'h0000_0000_1234_0000, 3'd0, 64'h0000_0000_0055_0000, 1'b0}, // R6 fetch ignores write
      {4'd2,  1'b0,1'b0,1'b0, 64'h0000_0000_800F_5432, 3'd0, 64'h0000_0001_2387_5000, 1'b1}, // R2 512K
      {4'd5,  1'b0,1'b0,1'b1, 64'h0000_0000_800F_5432, 3'd4, 64'h0,                   1'b0}, // R5 data
      {4'd5,  1'b1,1'b0,1'b1, 64'h0000_0000_8008_0000, 3'd3, 64'h0,                   1'b0}, // R5 fetch
      {4'd3,  1'b0,1'b0,1'b0, 64'hFFFF_FFFF_FFFF_F123, 3'd0, 64'h0000_01FF_FFFF_F000, 1'b1}, // R3 4M top of window
      {4'd7,  1'b0,1'b0,1'b0, 64'hFFFF_FFFF_FF80_0000, 3'd2, 64'h0,                   1'b0}, // R7 below 4M page
      {4'd4,  1'b0,1'b0,1'b0, 64'h0000_0000_0060_0010, 3'd4, 64'h0,                   1'b0}, // R4 data
      {4'd4,  1'b1,1'b0,1'b0, 64'h0000_0000_0060_0010, 3'd3, 64'h0,                   1'b0}, // R4 fetch
      {4'd8,  1'b0,1'b0,1'b0, 64'h0000_0000_0070_1FFF, 3'd0, 64'h0000_0000_0222_3000, 1'b1}, // R8 lowest index
      {4'd2,  1'b0,1'b0,1'b0, 64'h0000_0000_0090_0000, 3'd2, 64'h0,                   1'b0}, // R2 ctx mismatch
      {4'd7,  1'b1,1'b0,1'b0, 64'h0000_0000_0090_0000, 3'd1, 64'h0,                   1'b0}, // R7 fetch miss
      {4'd2,  1'b0,1'b0,1'b0, 64'h0000_0000_0040_2000, 3'd2, 64'h0,                   1'b0}  // R2 next page
   };

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load(input int idx, input logic [63:0] tag, input logic [63:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx[5:0]; wr_tag = tag; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input logic f, input logic w, input logic u, input logic [63:0] va);
      @(negedge clk);
      req_valid = 1'b1; req_fetch = f; req_write = w; req_user = u; req_va = va;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      fsr_clr = 1'b1;
      @(negedge clk);
      fsr_clr = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [63:0] pa_hold;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
      chk("R13", "dfsr", {60'd0, dfsr}, 64'd0);
      chk("R13", "ifsr", {60'd0, ifsr}, 64'd0);
      chk("R13", "dfar", dfar, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R13/R4: zeroed entries hit page 0 in context 0 and are invalid
      lookup(1'b0, 1'b0, 1'b0, 64'h1FFF);
      chk("R1", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
      chk("R4", "exc", {61'd0, rsp_exc}, 64'd4);
      chk("R11", "dfsr first", {60'd0, dfsr}, 64'h1);
      chk("R12", "dfar first", dfar, 64'h1FFF);
      pa_hold = rsp_pa;
      @(negedge clk);
      chk("R1", "rsp_valid drop", {63'd0, rsp_valid}, 64'd0);
      chk("R1", "pa hold", rsp_pa, pa_hold);

      lookup(1'b0, 1'b1, 1'b1, 64'h40);
      chk("R11", "dfsr overflow", {60'd0, dfsr}, 64'hF);
      chk("R12", "dfar second", dfar, 64'h40);
      pulse_clr();
      chk("R11", "dfsr clear", {60'd0, dfsr}, 64'h0);

      lookup(1'b1, 1'b0, 1'b1, 64'h0);
      chk("R4", "fetch exc", {61'd0, rsp_exc}, 64'd3);
      chk("R11", "ifsr first", {60'd0, ifsr}, 64'h9);
      chk("R12", "dfar kept", dfar, 64'h40);
      chk("R11", "dfsr kept", {60'd0, dfsr}, 64'h0);
      lookup(1'b1, 1'b1, 1'b0, 64'h0);
      chk("R11", "ifsr overflow", {60'd0, ifsr}, 64'h3);
      pulse_clr();
      chk("R11", "ifsr clear", {60'd0, ifsr}, 64'h0);

      // entries, context 5
      load(3,  64'h0000_0000_0040_0005, 64'h8000_0000_0AB0_0002);
      load(5,  64'h0000_0000_1234_0005, 64'hA000_0000_0055_0000);
      load(7,  64'h0000_0000_8008_0005, 64'hC000_0001_2380_0006);
      load(10, 64'hFFFF_FFFF_FFC0_0005, 64'hE004_01FF_FFC0_0042);
      load(12, 64'h0000_0000_0060_0005, 64'h0000_0000_0AAA_0002);
      load(21, 64'h0000_0000_0070_0005, 64'h8000_0000_0333_4002);
      load(20, 64'h0000_0000_0070_0005, 64'h8000_0000_0222_2002);
      load(30, 64'h0000_0000_0090_0006, 64'h8000_0000_0444_0002);
      ctx_id = 13'd5;

      for (int k = 0; k < NROWS; k++) begin
         logic [ROW_W-1:0] row;
         string rq;
         row = VEC[k];
         rq = $sformatf("R%0d row%0d", row[138:135], k);
         lookup(row[134], row[133], row[132], row[131:68]);
         chk(rq, "exc", {61'd0, rsp_exc}, {61'd0, row[67:65]});
         chk(rq, "pa", rsp_pa, row[64:1]);
         chk(rq, "wr_ok", {63'd0, rsp_wr_ok}, {63'd0, row[0]});
      end

      // R9 translation off
      pulse_clr();
      tr_enable = 1'b0;
      lookup(1'b0, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_1234);
      chk("R9", "bypass exc", {61'd0, rsp_exc}, 64'd0);
      chk("R9", "bypass pa", rsp_pa, 64'hDEAD_BEEF_0000_1234);
      chk("R9", "bypass wr_ok", {63'd0, rsp_wr_ok}, 64'd1);
      lookup(1'b1, 1'b0, 1'b1, 64'h0000_0000_0060_0010);
      chk("R9", "bypass fetch exc", {61'd0, rsp_exc}, 64'd0);
      chk("R9", "bypass fetch pa", rsp_pa, 64'h0000_0000_0060_0010);
      chk("R9", "bypass fetch wr_ok", {63'd0, rsp_wr_ok}, 64'd0);
      chk("R9", "dfsr untouched", {60'd0, dfsr}, 64'h0);
      chk("R9", "ifsr untouched", {60'd0, ifsr}, 64'h0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule